// File: doc/BRIEF.md
# Vector Butterfly Permutation Unit

This unit moves the elements of one vector register left or right by a power-of-two distance. It serves the reduction steps of dot products and the butterfly stages of FFT kernels. The register holds 128 elements of 16 bits each. The unit reads it over a 256-bit path, 16 elements per beat, and writes the permuted result into a separate destination register one full beat per cycle. It does not use a full crossbar. Each output beat is built from at most two source beats: a near beat and an adjacent far beat. The two are joined by a narrow in-beat shifter. Radices of 16 or more are handled by addressing a different near beat with no in-beat shift, and for those the far path stays idle.

An operation starts with a one-cycle `start` pulse. The pulse carries the direction, a 3-bit radix code and an active length. The unit then issues eight read beats in ascending order. Each write follows its read by a fixed two cycles, and a one-cycle `done` pulse comes one cycle after the last write. The surrounding register file returns read data one cycle after each request.

Top module: `vperm_bfly`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `rd_en`, `wr_en` and `done` are low.
- R2: A move-left sets destination element i to source element i+r. The result is zero where i+r is 128 or more.
- R3: A move-right sets destination element i to source element i−r. The result is zero where i is less than r.
- R4: Radix code c in 0..6 selects r = 2^c elements. Code 7 selects r = 0, which is a plain copy.
- R5: For r below 16 that is not 0, `rd_far_ok` is high when the adjacent source beat exists. That beat is one above the near beat for move-left and one below it for move-right. For r of 0 or r of 16 or more, `rd_far_ok` stays low.
- R6: On the t-th cycle after the start edge (t = 0..7), `rd_en` is high and the near beat is t+r/16 (left) or t−r/16 (right). `rd_near_ok` is low when that beat lies outside 0..7. `rd_en` is low after the eighth read.
- R7: The write for output beat b comes exactly two cycles after its read request. Beats 0 to 7 are written on consecutive cycles, with `wr_beat` = b.
- R8: Bit j of `wr_mask` is 1 exactly when element 16·b+j is below `vlen`. Masked-off destination elements keep their old value. A `vlen` of 128 or more writes every element, and a `vlen` of 0 writes none.
- R9: `done` is high for exactly one cycle, the cycle after the write of beat 7. That is ten cycles after the start edge.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes unchanged, with exactly eight writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| dir_left | input | 1 | 1: move left (i+r), 0: move right (i−r) |
| radix_code | input | 3 | log2 of radix, 7 means copy |
| vlen | input | 8 | Number of active elements |
| busy | output | 1 | Operation in progress |
| rd_en | output | 1 | Read request for this cycle |
| rd_near_beat | output | 3 | Near source beat index |
| rd_near_ok | output | 1 | Near beat exists; data used |
| rd_far_beat | output | 3 | Far (adjacent) source beat index |
| rd_far_ok | output | 1 | Far beat exists and is needed |
| rd_near_data | input | 256 | Near beat data, one cycle after request |
| rd_far_data | input | 256 | Far beat data, one cycle after request |
| wr_en | output | 1 | Destination beat write |
| wr_beat | output | 3 | Destination beat index |
| wr_mask | output | 16 | Per-element write enable |
| wr_data | output | 256 | Permuted beat |
| done | output | 1 | Completion pulse |

## Verification
Counting from the clock edge that samples `start`:
- The read request for beat t is visible in cycle t after that edge.
- The write of beat b is visible in cycle b+2.
- `done` is visible in cycle 10 and drops in cycle 11.

The bench counts rising edges and stamps each expected write with the cycle in which it is due. It samples everything at the falling edge, and the monitor rejects a write whose cycle, beat, mask or data differ from the stamped item. Read requests are compared by the driver cycle by cycle. The destination image is compared element by element after `done`, which also covers the elements that must keep their old values.

// File: rtl/vperm_bfly_pkg.sv
`timescale 1ns/1ps
package vperm_bfly_pkg;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } move_dir_e;

endpackage

// File: rtl/vperm_bfly_decode.sv
`timescale 1ns/1ps
// Splits a radix code into an in-beat element shift and a whole-beat step.
module vperm_bfly_decode #(
    parameter int EPB    = 16,
    parameter int NB     = 8,
    parameter int CODE_W = 3,
    localparam int SHIFT_W = $clog2(EPB),
    localparam int STEP_W  = $clog2(NB) + 1
) (
    input  logic [CODE_W-1:0]  code,
    output logic [SHIFT_W-1:0] shift_elems,
    output logic [STEP_W-1:0]  step_beats
);
    int unsigned radix;

    always_comb begin
        radix       = 0;
        shift_elems = '0;
        step_beats  = '0;
        // all-ones code is the copy case: no movement at all
        if (code != '1) begin
            radix       = 32'd1 << code;
            shift_elems = SHIFT_W'(radix % 32'(EPB));
            step_beats  = STEP_W'(radix / 32'(EPB));
        end
    end
endmodule

// File: rtl/vperm_bfly_addr.sv
`timescale 1ns/1ps
// Works out which source beats feed one output beat.
module vperm_bfly_addr
    import vperm_bfly_pkg::*;
#(
    parameter int NB      = 8,
    parameter int SHIFT_W = 4,
    parameter int STEP_W  = 4,
    localparam int BIDX_W = $clog2(NB),
    localparam int SUM_W  = BIDX_W + 2
) (
    input  logic [BIDX_W-1:0]  beat,
    input  move_dir_e          dir,
    input  logic [SHIFT_W-1:0] shift_elems,
    input  logic [STEP_W-1:0]  step_beats,
    output logic [BIDX_W-1:0]  near_beat,
    output logic               near_ok,
    output logic [BIDX_W-1:0]  far_beat,
    output logic               far_ok
);
    logic [SUM_W-1:0] near_sum;
    logic [SUM_W-1:0] far_sum;
    logic [SUM_W-1:0] beat_x;
    logic [SUM_W-1:0] step_x;

    assign beat_x = SUM_W'(beat);
    assign step_x = SUM_W'(step_beats);

    always_comb begin
        near_sum = '0;
        far_sum  = '0;
        near_ok  = 1'b0;
        far_ok   = 1'b0;
        if (dir == DIR_LEFT) begin
            near_sum = beat_x + step_x;
            far_sum  = near_sum + 1'b1;
            near_ok  = near_sum < SUM_W'(NB);
            far_ok   = (shift_elems != '0) && (far_sum < SUM_W'(NB));
        end else begin
            near_sum = beat_x - step_x;
            far_sum  = near_sum - 1'b1;
            near_ok  = beat_x >= step_x;
            far_ok   = (shift_elems != '0) && (beat_x > step_x);
        end
    end

    assign near_beat = near_sum[BIDX_W-1:0];
    assign far_beat  = far_sum[BIDX_W-1:0];
endmodule

// File: rtl/vperm_bfly_shift.sv
`timescale 1ns/1ps
// Joins near and far beats into a double-width window and slides it.
module vperm_bfly_shift
    import vperm_bfly_pkg::*;
#(
    parameter int ELEM_W  = 16,
    parameter int EPB     = 16,
    parameter int SHIFT_W = 4,
    localparam int BEAT_W = ELEM_W * EPB,
    localparam int AMT_W  = $clog2(2 * BEAT_W) + 1
) (
    input  logic [BEAT_W-1:0]  near_data,
    input  logic [BEAT_W-1:0]  far_data,
    input  logic               near_ok,
    input  logic               far_ok,
    input  move_dir_e          dir,
    input  logic [SHIFT_W-1:0] shift_elems,
    output logic [BEAT_W-1:0]  result
);
    logic [BEAT_W-1:0]   near_m;
    logic [BEAT_W-1:0]   far_m;
    logic [2*BEAT_W-1:0] window;
    logic [2*BEAT_W-1:0] moved;
    logic [AMT_W-1:0]    amt;

    assign near_m = near_ok ? near_data : '0;
    assign far_m  = far_ok  ? far_data  : '0;
    assign amt    = AMT_W'(shift_elems) * AMT_W'(ELEM_W);

    always_comb begin
        if (dir == DIR_LEFT) begin
            // higher-numbered elements slide down into this beat
            window = {far_m, near_m};
            moved  = window >> amt;
            result = moved[BEAT_W-1:0];
        end else begin
            // lower-numbered elements slide up into this beat
            window = {near_m, far_m};
            moved  = window << amt;
            result = moved[2*BEAT_W-1:BEAT_W];
        end
    end
endmodule

// File: rtl/vperm_bfly_mask.sv
`timescale 1ns/1ps
// Per-element write enables from the active length.
module vperm_bfly_mask #(
    parameter int EPB  = 16,
    parameter int NB   = 8,
    localparam int BIDX_W = $clog2(NB),
    localparam int VL_W   = $clog2(EPB * NB + 1)
) (
    input  logic [BIDX_W-1:0] beat,
    input  logic [VL_W-1:0]   vlen,
    output logic [EPB-1:0]    mask
);
    logic [VL_W-1:0] base;

    assign base = VL_W'(beat) * VL_W'(EPB);

    for (genvar g = 0; g < EPB; g++) begin : g_elem
        assign mask[g] = (base + VL_W'(g)) < vlen;
    end
endmodule

// File: rtl/vperm_bfly.sv
`timescale 1ns/1ps
module vperm_bfly
    import vperm_bfly_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int EPB    = 16,
    parameter int NB     = 8,
    parameter int CODE_W = 3,
    localparam int BEAT_W  = ELEM_W * EPB,
    localparam int BIDX_W  = $clog2(NB),
    localparam int VL_W    = $clog2(EPB * NB + 1),
    localparam int SHIFT_W = $clog2(EPB),
    localparam int STEP_W  = $clog2(NB) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_left,
    input  logic [CODE_W-1:0] radix_code,
    input  logic [VL_W-1:0]   vlen,
    output logic              busy,
    output logic              rd_en,
    output logic [BIDX_W-1:0] rd_near_beat,
    output logic              rd_near_ok,
    output logic [BIDX_W-1:0] rd_far_beat,
    output logic              rd_far_ok,
    input  logic [BEAT_W-1:0] rd_near_data,
    input  logic [BEAT_W-1:0] rd_far_data,
    output logic              wr_en,
    output logic [BIDX_W-1:0] wr_beat,
    output logic [EPB-1:0]    wr_mask,
    output logic [BEAT_W-1:0] wr_data,
    output logic              done
);
    typedef struct packed {
        move_dir_e          dir;
        logic [SHIFT_W-1:0] shift;
        logic [STEP_W-1:0]  step;
        logic [VL_W-1:0]    vlen;
        logic               iss_act;
        logic [BIDX_W-1:0]  iss_beat;
        logic               s1_vld;
        logic [BIDX_W-1:0]  s1_beat;
        logic               s1_near_ok;
        logic               s1_far_ok;
        logic               out_vld;
        logic [BIDX_W-1:0]  out_beat;
        logic [EPB-1:0]     out_mask;
        logic [BEAT_W-1:0]  out_data;
        logic               done;
    } state_t;

    state_t st_d, st_q;

    logic [SHIFT_W-1:0] dec_shift;
    logic [STEP_W-1:0]  dec_step;
    logic [BIDX_W-1:0]  near_beat, far_beat;
    logic               near_ok, far_ok;
    logic [BEAT_W-1:0]  perm_beat;
    logic [EPB-1:0]     beat_mask;
    logic               accept;

    vperm_bfly_decode #(.EPB(EPB), .NB(NB), .CODE_W(CODE_W)) u_decode (
        .code        (radix_code),
        .shift_elems (dec_shift),
        .step_beats  (dec_step)
    );

    vperm_bfly_addr #(.NB(NB), .SHIFT_W(SHIFT_W), .STEP_W(STEP_W)) u_addr (
        .beat        (st_q.iss_beat),
        .dir         (st_q.dir),
        .shift_elems (st_q.shift),
        .step_beats  (st_q.step),
        .near_beat   (near_beat),
        .near_ok     (near_ok),
        .far_beat    (far_beat),
        .far_ok      (far_ok)
    );

    vperm_bfly_shift #(.ELEM_W(ELEM_W), .EPB(EPB), .SHIFT_W(SHIFT_W)) u_shift (
        .near_data   (rd_near_data),
        .far_data    (rd_far_data),
        .near_ok     (st_q.s1_near_ok),
        .far_ok      (st_q.s1_far_ok),
        .dir         (st_q.dir),
        .shift_elems (st_q.shift),
        .result      (perm_beat)
    );

    vperm_bfly_mask #(.EPB(EPB), .NB(NB)) u_mask (
        .beat (st_q.s1_beat),
        .vlen (st_q.vlen),
        .mask (beat_mask)
    );

    assign busy   = st_q.iss_act | st_q.s1_vld | st_q.out_vld;
    assign accept = start & ~busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        // issue stage: one read request per cycle, beats ascending
        if (accept) begin
            st_d.dir      = move_dir_e'(dir_left);
            st_d.shift    = dec_shift;
            st_d.step     = dec_step;
            st_d.vlen     = vlen;
            st_d.iss_act  = 1'b1;
            st_d.iss_beat = '0;
        end else if (st_q.iss_act) begin
            if (st_q.iss_beat == BIDX_W'(NB - 1)) begin
                st_d.iss_act = 1'b0;
            end else begin
                st_d.iss_beat = st_q.iss_beat + 1'b1;
            end
        end

        // data-return stage: source beats arrive while this is valid
        st_d.s1_vld     = st_q.iss_act;
        st_d.s1_beat    = st_q.iss_beat;
        st_d.s1_near_ok = st_q.iss_act & near_ok;
        st_d.s1_far_ok  = st_q.iss_act & far_ok;

        // write stage
        st_d.out_vld  = st_q.s1_vld;
        st_d.out_beat = st_q.s1_beat;
        st_d.out_mask = st_q.s1_vld ? beat_mask : '0;
        st_d.out_data = perm_beat;

        if (st_q.out_vld && (st_q.out_beat == BIDX_W'(NB - 1))) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en        = st_q.iss_act;
    assign rd_near_beat = near_beat;
    assign rd_near_ok   = st_q.iss_act & near_ok;
    assign rd_far_beat  = far_beat;
    assign rd_far_ok    = st_q.iss_act & far_ok;
    assign wr_en        = st_q.out_vld;
    assign wr_beat      = st_q.out_beat;
    assign wr_mask      = st_q.out_mask;
    assign wr_data      = st_q.out_data;
    assign done         = st_q.done;
endmodule

// File: rtl/vperm_bfly_chk.sv
`timescale 1ns/1ps
module vperm_bfly_chk #(
    parameter int NB = 8,
    localparam int BIDX_W = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rd_en,
    input logic [BIDX_W-1:0] rd_near_beat,
    input logic              rd_near_ok,
    input logic [BIDX_W-1:0] rd_far_beat,
    input logic              rd_far_ok,
    input logic              wr_en,
    input logic [BIDX_W-1:0] wr_beat,
    input logic              done
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_beat) == BIDX_W'(NB - 1)))); // R9

    AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_beat != BIDX_W'(NB - 1))) |=> (wr_en && (wr_beat == $past(wr_beat) + 1'b1))); // R7

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en, 2)); // R7

    AST_FAR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_far_ok |-> (rd_en && rd_near_ok &&
                       ((rd_far_beat == rd_near_beat + 1'b1) || (rd_far_beat == rd_near_beat - 1'b1)))); // R5

    AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R10
endmodule

bind vperm_bfly vperm_bfly_chk #(.NB(NB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .rd_en        (rd_en),
    .rd_near_beat (rd_near_beat),
    .rd_near_ok   (rd_near_ok),
    .rd_far_beat  (rd_far_beat),
    .rd_far_ok    (rd_far_ok),
    .wr_en        (wr_en),
    .wr_beat      (wr_beat),
    .done         (done)
);

// File: tb/vperm_bfly_tb.sv
`timescale 1ns/1ps
module vperm_bfly_tb;
    localparam int ELEM_W = 16;
    localparam int EPB    = 16;
    localparam int NB     = 8;
    localparam int NE     = EPB * NB;
    localparam int BEAT_W = ELEM_W * EPB;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic              dir_left;
    logic [2:0]        radix_code;
    logic [7:0]        vlen;
    logic              busy, rd_en, rd_near_ok, rd_far_ok, wr_en, done;
    logic [2:0]        rd_near_beat, rd_far_beat, wr_beat;
    logic [BEAT_W-1:0] rd_near_data, rd_far_data, wr_data;
    logic [EPB-1:0]    wr_mask;

    logic [BEAT_W-1:0] src_mem [NB];
    logic [BEAT_W-1:0] dst_mem [NB];

    typedef struct {
        int                beat;
        logic [EPB-1:0]    mask;
        logic [BEAT_W-1:0] data;
        int                due;
        string             req;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_item;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_wr = 0;
    int   seed = 0;

    always #4 clk = ~clk;

    vperm_bfly u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_left(dir_left),
        .radix_code(radix_code), .vlen(vlen), .busy(busy), .rd_en(rd_en),
        .rd_near_beat(rd_near_beat), .rd_near_ok(rd_near_ok),
        .rd_far_beat(rd_far_beat), .rd_far_ok(rd_far_ok),
        .rd_near_data(rd_near_data), .rd_far_data(rd_far_data),
        .wr_en(wr_en), .wr_beat(wr_beat), .wr_mask(wr_mask),
        .wr_data(wr_data), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // register file model: registered read, masked write
    always @(posedge clk) begin
        if (rd_en) begin
            rd_near_data <= src_mem[rd_near_beat];
            rd_far_data  <= src_mem[rd_far_beat];
        end
        if (wr_en) begin
            for (int j = 0; j < EPB; j++) begin
                if (wr_mask[j]) dst_mem[wr_beat][j*ELEM_W +: ELEM_W] <= wr_data[j*ELEM_W +: ELEM_W];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [BEAT_W-1:0] act, input logic [BEAT_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ELEM_W-1:0] src_el(input int i);
        return src_mem[i / EPB][(i % EPB)*ELEM_W +: ELEM_W];
    endfunction

    function automatic logic [ELEM_W-1:0] exp_el(input int i, input bit left, input int code);
        int r;
        int si;
        r  = (code == 7) ? 0 : (1 << code);
        si = left ? i + r : i - r;
        if (si < 0 || si >= NE) return '0;
        return src_el(si);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            n_wr++;
            if (sbq.size() == 0) begin
                chk(1'b0, "R7 unexpected write", BEAT_W'(wr_beat), '0);
            end else begin
                mon_item = sbq.pop_front();
                chk((int'(wr_beat) == mon_item.beat) && (cyc == mon_item.due), "R7 write beat/cycle",
                    (BEAT_W'(cyc) << 8) | BEAT_W'(wr_beat),
                    (BEAT_W'(mon_item.due) << 8) | BEAT_W'(mon_item.beat));
                chk(wr_mask == mon_item.mask, "R8 write mask", BEAT_W'(wr_mask), BEAT_W'(mon_item.mask));
                chk(wr_data == mon_item.data, mon_item.req, wr_data, mon_item.data);
            end
        end
    end

    task automatic run_op(input bit left, input int code, input int vl, input bit inject);
        int r, s, k, c0, wr0, nb, fb, idx;
        bit nok, fok, ok;
        logic [BEAT_W-1:0] pre [NB];
        logic [ELEM_W-1:0] want, got;
        exp_t it;
        string tag;
        r   = (code == 7) ? 0 : (1 << code);
        s   = r % EPB;
        k   = r / EPB;
        tag = (code == 7) ? "R4 copy data" : (left ? "R2 left data" : "R3 right data");
        seed++;
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < EPB; j++) begin
                src_mem[b][j*ELEM_W +: ELEM_W] = {8'(seed), 8'(b*EPB + j)};
                dst_mem[b][j*ELEM_W +: ELEM_W] = {8'hD0 ^ 8'(seed), 8'(b*EPB + j)};
            end
            pre[b] = dst_mem[b];
        end
        @(negedge clk);
        c0  = cyc;
        wr0 = n_wr;
        for (int b = 0; b < NB; b++) begin
            it.beat = b;
            it.due  = c0 + 3 + b;
            it.req  = tag;
            for (int j = 0; j < EPB; j++) begin
                idx = b*EPB + j;
                it.data[j*ELEM_W +: ELEM_W] = exp_el(idx, left, code);
                it.mask[j] = (idx < vl);
            end
            sbq.push_back(it);
        end
        start = 1'b1; dir_left = left; radix_code = 3'(code); vlen = 8'(vl);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < NB; t++) begin
            if (t > 0) @(negedge clk);
            if (inject && t == 2) begin
                start = 1'b1; dir_left = ~left; radix_code = 3'((code + 1) % 7); vlen = 8'd128;
            end
            if (inject && t == 3) start = 1'b0;
            nb  = left ? t + k : t - k;
            nok = (nb >= 0) && (nb < NB);
            fb  = left ? t + k + 1 : t - k - 1;
            fok = (s != 0) && (fb >= 0) && (fb < NB);
            chk(rd_en == 1'b1, "R6 read enable", BEAT_W'(rd_en), 1);
            chk(rd_near_ok == nok, "R6 near ok", BEAT_W'(rd_near_ok), BEAT_W'(nok));
            if (nok) chk(int'(rd_near_beat) == nb, "R6 near beat", BEAT_W'(rd_near_beat), BEAT_W'(nb));
            chk(rd_far_ok == fok, "R5 far ok", BEAT_W'(rd_far_ok), BEAT_W'(fok));
            if (fok) chk(int'(rd_far_beat) == fb, "R5 far beat", BEAT_W'(rd_far_beat), BEAT_W'(fb));
        end
        @(negedge clk);
        chk(rd_en == 1'b0, "R6 reads stop", BEAT_W'(rd_en), 0);
        chk(done == 1'b0, "R9 done early", BEAT_W'(done), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done early", BEAT_W'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R9 done due", BEAT_W'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single pulse", BEAT_W'(done), 0);
        chk(sbq.size() == 0, "R7 all beats written", BEAT_W'(sbq.size()), 0);
        if (inject) chk((n_wr - wr0) == NB, "R10 start while busy ignored", BEAT_W'(n_wr - wr0), BEAT_W'(NB));
        ok   = 1'b1;
        want = '0;
        got  = '0;
        for (int i = 0; i < NE; i++) begin
            logic [ELEM_W-1:0] w, g;
            w = (i < vl) ? exp_el(i, left, code) : pre[i / EPB][(i % EPB)*ELEM_W +: ELEM_W];
            g = dst_mem[i / EPB][(i % EPB)*ELEM_W +: ELEM_W];
            if (ok && (w != g)) begin
                ok = 1'b0; want = w; got = g;
            end
        end
        chk(ok, "R8 destination image", BEAT_W'(got), BEAT_W'(want));
        sbq.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; dir_left = 1'b0; radix_code = '0; vlen = '0;
        repeat (3) @(negedge clk);
        chk({busy, rd_en, wr_en, done} == 4'b0, "R1 reset outputs", BEAT_W'({busy, rd_en, wr_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, rd_en, wr_en, done} == 4'b0, "R1 after reset", BEAT_W'({busy, rd_en, wr_en, done}), 0);

        run_op(1'b1, 0, 128, 1'b0);   // R2 radix 1
        run_op(1'b0, 0, 128, 1'b0);   // R3 radix 1
        run_op(1'b1, 2, 100, 1'b0);   // R2 R8 radix 4, partial length
        run_op(1'b0, 3, 128, 1'b0);   // R3 radix 8
        run_op(1'b1, 4, 128, 1'b0);   // R4 radix 16: beat step only
        run_op(1'b0, 5, 64, 1'b0);    // R4 radix 32 right, half length
        run_op(1'b1, 6, 128, 1'b0);   // R4 radix 64 left
        run_op(1'b0, 6, 128, 1'b0);   // R4 radix 64 right
        run_op(1'b0, 7, 37, 1'b0);    // R4 copy code
        run_op(1'b1, 1, 0, 1'b0);     // R8 zero length
        run_op(1'b0, 1, 200, 1'b0);   // R8 length above 128
        run_op(1'b1, 3, 90, 1'b1);    // R10 ignored start

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule